// File: doc/BRIEF.md
# Serial GPIO Burst Shift Engine

This block turns an external daisy chain of shift registers into a large set of virtual GPIO pins. The chain is organised as up to 32 ports, and every port carries the same number of bits, from 1 to 4. In each burst the engine walks the enabled ports and shifts one output level out on a data pin for every port bit. On the same serial clock it shifts the returning input level in on a second pin. It ends the burst with a load strobe, which latches the chain's parallel outputs and captures its parallel inputs.

Software controls the engine through a simple register-style write/read port. Through it, software sets the bits per port, the enabled-port mask, the serial clock divider and the gap between bursts. Two burst modes are available: free-running repetition, and a one-off burst that is triggered by a self-clearing bit. Every output bit takes its level from a 3-bit source field in its port's source word. Captured inputs are returned as one word per bit index, holding one bit per port.

Top module: `sgpio_burst_engine`

## Requirements
- R1: After a synchronous active-low reset, `sio_clk`, `sio_dout` and `sio_load` are low and every readable register returns zero.
- R2: The serial period is D system cycles, where D is the divider register (address 0x01, bits 11:0) clamped to at least 2. Within each shift slot, `sio_clk` is low for the first floor(D/2) cycles and high for the rest. It is low outside shift slots.
- R3: A burst visits the enabled ports (address 0x03, one bit per port) in ascending port order, and within each port it visits bits 0 up to the width field. The width field is control bits 1:0 and holds bits per port minus one. Each visit is one serial period. Disabled ports are skipped.
- R4: During the slot for port p, bit b, `sio_dout` is 1 only when the 3-bit field at bit offset 3*b of the source word for port p (address 0x20+p) holds 1. Values 0 and 2 to 7 give 0.
- R5: After the last slot, `sio_load` is high for exactly one serial period with `sio_clk` and `sio_dout` low. With an empty port mask, the burst consists of this load period alone.
- R6: `sio_din` is sampled in the last system cycle of each shift slot. The captured word for bit b is at address 0x04+b, with bit p holding port p. It changes only at the end of a burst's load period. Positions not visited in that burst read 0.
- R7: With auto-repeat (control bit 2) set at the end of a burst, a gap of G serial periods follows, where G is the gap register at address 0x02. Then one idle cycle passes and the next burst starts. With G equal to 0, only the idle cycle separates bursts.
- R8: When single-shot (control bit 3) is set while the engine is idle, a burst starts on the second cycle after the write. If auto-repeat is clear when that burst ends, the engine clears single-shot on its own.
- R9: While auto-repeat is set, the single-shot bit is never cleared by the engine.
- R10: Port mask, width and divider are taken once, when a burst starts. Writes to them during a burst take effect from the next burst.
- R11: Writes to the captured-input addresses or to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address for both write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| sio_clk | output | 1 | Serial shift clock to the chain |
| sio_dout | output | 1 | Serial output data to the chain |
| sio_load | output | 1 | Chain latch strobe, one serial period wide |
| sio_din | input | 1 | Serial input data returning from the chain |

## Verification
The pin outputs are decoded from state registers, so their change is due in the first cycle after the clock edge that moves the state. The bench compares all three pins against its reference model on every falling edge. Its burst queue is filled on the edge that sees the start condition, so a single-shot write produces its first slot on the second cycle. Captured words and the self-clear of single-shot are due in the cycle after the last load cycle. The bench therefore reads them back only after its model queue has drained. Register reads are combinational, and each is sampled 1 ns after the address is driven.

// File: rtl/sgpio_pkg.sv
// Shared constants, state type and helpers for the serial GPIO burst engine.
// Assumes a 6-bit register address space and 32-bit register data.
package sgpio_pkg;

    localparam int ADDR_W = 6;
    localparam int CFG_DW = 32;
    localparam int SRC_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2,
        ST_GAP   = 2'd3
    } seq_state_e;

    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
    localparam logic [ADDR_W-1:0] A_CLKDIV = 6'h01;
    localparam logic [ADDR_W-1:0] A_GAP    = 6'h02;
    localparam logic [ADDR_W-1:0] A_PORTEN = 6'h03;
    localparam logic [ADDR_W-1:0] A_INWORD = 6'h04;
    localparam logic [ADDR_W-1:0] A_SRC    = 6'h20;

    // Level driven for one 3-bit source field; reserved codes give 0.
    function automatic logic src_level(input logic [SRC_W-1:0] f);
        return (f == 3'd1);
    endfunction

endpackage

// File: rtl/sgpio_cfg_regs.sv
// Configuration register file: control, divider, gap, port mask, per-port
// source words, and read-back of captured input words.
// Assumes NUM_PORTS <= 32 and a single-cycle write strobe.
module sgpio_cfg_regs
    import sgpio_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int MAX_BITS  = 4,
    parameter int DIV_W     = 12,
    parameter int GAP_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [CFG_DW-1:0]             wdata,
    output logic [CFG_DW-1:0]             rdata,
    input  logic                          shot_done,
    input  logic [MAX_BITS*NUM_PORTS-1:0] in_flat,
    output logic [$clog2(MAX_BITS)-1:0]   width_m1,
    output logic                          auto_rep,
    output logic                          single_shot,
    output logic [DIV_W-1:0]              clk_div,
    output logic [GAP_W-1:0]              gap_len,
    output logic [NUM_PORTS-1:0]          port_en,
    output logic [NUM_PORTS*MAX_BITS*SRC_W-1:0] src_flat
);
    localparam int BIT_W      = $clog2(MAX_BITS);
    localparam int SRC_WORD_W = MAX_BITS * SRC_W;

    logic [SRC_WORD_W-1:0] src_q [NUM_PORTS];
    logic                  ctrl_hit;

    assign ctrl_hit = we && (addr == A_CTRL);

    // Width and auto-repeat fields of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_m1 <= '0;
            auto_rep <= 1'b0;
        end else if (ctrl_hit) begin
            width_m1 <= wdata[BIT_W-1:0];
            auto_rep <= wdata[BIT_W];
        end
    end

    // Single-shot bit: software write wins, else cleared when a one-off burst ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_shot <= 1'b0;
        end else if (ctrl_hit) begin
            single_shot <= wdata[BIT_W+1];
        end else if (shot_done && !auto_rep) begin
            single_shot <= 1'b0;
        end
    end

    // Divider, gap and port-mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_div <= '0;
            gap_len <= '0;
            port_en <= '0;
        end else if (we) begin
            if (addr == A_CLKDIV) clk_div <= wdata[DIV_W-1:0];
            if (addr == A_GAP)    gap_len <= wdata[GAP_W-1:0];
            if (addr == A_PORTEN) port_en <= wdata[NUM_PORTS-1:0];
        end
    end

    // One source word per port, flattened for the output mux.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q[p] <= '0;
            end else if (we && (addr == A_SRC + ADDR_W'(p))) begin
                src_q[p] <= wdata[SRC_WORD_W-1:0];
            end
        end
        assign src_flat[p*SRC_WORD_W +: SRC_WORD_W] = src_q[p];
    end

    // Combinational read mux over all readable addresses.
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[BIT_W+1:0] = {single_shot, auto_rep, width_m1};
        end else if (addr == A_CLKDIV) begin
            rdata[DIV_W-1:0] = clk_div;
        end else if (addr == A_GAP) begin
            rdata[GAP_W-1:0] = gap_len;
        end else if (addr == A_PORTEN) begin
            rdata[NUM_PORTS-1:0] = port_en;
        end
        for (int b = 0; b < MAX_BITS; b++) begin
            if (addr == A_INWORD + ADDR_W'(b)) begin
                rdata[NUM_PORTS-1:0] = in_flat[b*NUM_PORTS +: NUM_PORTS];
            end
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr == A_SRC + ADDR_W'(p)) begin
                rdata[SRC_WORD_W-1:0] = src_q[p];
            end
        end
    end

endmodule

// File: rtl/sgpio_period_timer.sv
// Serial period timer: counts system cycles inside one serial period and
// flags its last cycle and its high half. Assumes div >= 2 and stable
// while active.
module sgpio_period_timer #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [DIV_W-1:0] div,
    output logic             period_end,
    output logic             phase_high
);
    logic [DIV_W-1:0] cnt;

    assign period_end = active && (cnt == div - DIV_W'(1));
    assign phase_high = (cnt >= (div >> 1));

    // Cycle counter, restarted at each period end and held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active || period_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/sgpio_sequencer.sv
// Burst sequencer: decides when a burst starts, snapshots the chain
// geometry and divider, walks enabled ports and bits, then load and gap.
// Assumes NUM_PORTS >= 2.
module sgpio_sequencer
    import sgpio_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int MAX_BITS  = 4,
    parameter int DIV_W     = 12,
    parameter int GAP_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         auto_rep,
    input  logic                         single_shot,
    input  logic [$clog2(MAX_BITS)-1:0]  width_m1,
    input  logic [NUM_PORTS-1:0]         port_en,
    input  logic [DIV_W-1:0]             clk_div,
    input  logic [GAP_W-1:0]             gap_len,
    input  logic                         period_end,
    output seq_state_e                   state,
    output logic [$clog2(NUM_PORTS)-1:0] cur_port,
    output logic [$clog2(MAX_BITS)-1:0]  cur_bit,
    output logic [DIV_W-1:0]             div_snap,
    output logic                         start,
    output logic                         burst_done,
    output logic                         sample
);
    localparam int PORT_W = $clog2(NUM_PORTS);
    localparam int BIT_W  = $clog2(MAX_BITS);

    logic [NUM_PORTS-1:0] mask_q;
    logic [BIT_W-1:0]     width_q;
    logic [GAP_W-1:0]     gap_left;
    logic [PORT_W:0]      first_hit;
    logic [PORT_W:0]      next_hit;
    logic [DIV_W-1:0]     div_eff;

    // Lowest set mask bit at or above 'from'; MSB of the result flags a hit.
    function automatic logic [PORT_W:0] find_from(input logic [NUM_PORTS-1:0] m,
                                                  input int from);
        logic [PORT_W:0] r;
        r = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (i >= from && m[i]) r = {1'b1, PORT_W'(i)};
        end
        return r;
    endfunction

    // Search results for the first port of a burst and the port after the current one.
    always_comb begin
        first_hit = find_from(port_en, 0);
        next_hit  = find_from(mask_q, int'(cur_port) + 1);
    end

    assign div_eff    = (clk_div < DIV_W'(2)) ? DIV_W'(2) : clk_div;
    assign start      = (state == ST_IDLE) && (auto_rep || single_shot);
    assign burst_done = (state == ST_LOAD) && period_end;
    assign sample     = (state == ST_SHIFT) && period_end;

    // Main burst state machine with per-burst snapshots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_port <= '0;
            cur_bit  <= '0;
            mask_q   <= '0;
            width_q  <= '0;
            div_snap <= DIV_W'(2);
            gap_left <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mask_q   <= port_en;
                        width_q  <= width_m1;
                        div_snap <= div_eff;
                        cur_bit  <= '0;
                        if (first_hit[PORT_W]) begin
                            state    <= ST_SHIFT;
                            cur_port <= first_hit[PORT_W-1:0];
                        end else begin
                            state <= ST_LOAD;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (period_end) begin
                        if (cur_bit == width_q) begin
                            cur_bit <= '0;
                            if (next_hit[PORT_W]) begin
                                cur_port <= next_hit[PORT_W-1:0];
                            end else begin
                                state <= ST_LOAD;
                            end
                        end else begin
                            cur_bit <= cur_bit + BIT_W'(1);
                        end
                    end
                end
                ST_LOAD: begin
                    if (period_end) begin
                        if (auto_rep && (gap_len != '0)) begin
                            state    <= ST_GAP;
                            gap_left <= gap_len;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    if (period_end) begin
                        if (gap_left == GAP_W'(1)) begin
                            state <= ST_IDLE;
                        end else begin
                            gap_left <= gap_left - GAP_W'(1);
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/sgpio_capture.sv
// Input capture: collects serial input bits into a shadow array during a
// burst and publishes it as the visible input words when the burst ends.
// Assumes sample and commit never coincide.
module sgpio_capture #(
    parameter int NUM_PORTS = 32,
    parameter int MAX_BITS  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          sample,
    input  logic                          commit,
    input  logic [$clog2(NUM_PORTS)-1:0]  cur_port,
    input  logic [$clog2(MAX_BITS)-1:0]   cur_bit,
    input  logic                          sdi,
    output logic [MAX_BITS*NUM_PORTS-1:0] in_flat
);
    logic [MAX_BITS-1:0][NUM_PORTS-1:0] shadow;
    logic [MAX_BITS-1:0][NUM_PORTS-1:0] words;

    // Shadow array: cleared at burst start, one bit written per shift slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (start) begin
            shadow <= '0;
        end else if (sample) begin
            shadow[cur_bit][cur_port] <= sdi;
        end
    end

    // Visible input words, replaced only at the end of a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
        end else if (commit) begin
            words <= shadow;
        end
    end

    assign in_flat = words;

endmodule

// File: rtl/sgpio_burst_engine.sv
// Top of the serial GPIO burst engine. Connects the register file, burst
// sequencer, period timer and capture logic, and decodes the chain pins
// from sequencer state. Pins are combinational from registers.
module sgpio_burst_engine
    import sgpio_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int MAX_BITS  = 4,
    parameter int DIV_W     = 12,
    parameter int GAP_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic              sio_clk,
    output logic              sio_dout,
    output logic              sio_load,
    input  logic              sio_din
);
    localparam int PORT_W     = $clog2(NUM_PORTS);
    localparam int BIT_W      = $clog2(MAX_BITS);
    localparam int SRC_WORD_W = MAX_BITS * SRC_W;
    localparam int IN_BITS    = MAX_BITS * NUM_PORTS;

    logic [BIT_W-1:0]                width_m1;
    logic                            ctrl_auto;
    logic                            ctrl_ss;
    logic [DIV_W-1:0]                clk_div;
    logic [GAP_W-1:0]                gap_len;
    logic [NUM_PORTS-1:0]            port_en;
    logic [NUM_PORTS*SRC_WORD_W-1:0] src_flat;
    logic [IN_BITS-1:0]              in_flat;
    seq_state_e                      state;
    logic [PORT_W-1:0]               cur_port;
    logic [BIT_W-1:0]                cur_bit;
    logic [DIV_W-1:0]                div_snap;
    logic                            start;
    logic                            burst_done;
    logic                            sample;
    logic                            period_end;
    logic                            phase_high;
    logic                            busy;
    logic [SRC_WORD_W-1:0]           cur_word;
    logic [SRC_W-1:0]                cur_field;

    sgpio_cfg_regs #(
        .NUM_PORTS(NUM_PORTS), .MAX_BITS(MAX_BITS), .DIV_W(DIV_W), .GAP_W(GAP_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .shot_done  (burst_done),
        .in_flat    (in_flat),
        .width_m1   (width_m1),
        .auto_rep   (ctrl_auto),
        .single_shot(ctrl_ss),
        .clk_div    (clk_div),
        .gap_len    (gap_len),
        .port_en    (port_en),
        .src_flat   (src_flat)
    );

    sgpio_sequencer #(
        .NUM_PORTS(NUM_PORTS), .MAX_BITS(MAX_BITS), .DIV_W(DIV_W), .GAP_W(GAP_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_rep   (ctrl_auto),
        .single_shot(ctrl_ss),
        .width_m1   (width_m1),
        .port_en    (port_en),
        .clk_div    (clk_div),
        .gap_len    (gap_len),
        .period_end (period_end),
        .state      (state),
        .cur_port   (cur_port),
        .cur_bit    (cur_bit),
        .div_snap   (div_snap),
        .start      (start),
        .burst_done (burst_done),
        .sample     (sample)
    );

    assign busy = (state != ST_IDLE);

    sgpio_period_timer #(.DIV_W(DIV_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (busy),
        .div       (div_snap),
        .period_end(period_end),
        .phase_high(phase_high)
    );

    sgpio_capture #(.NUM_PORTS(NUM_PORTS), .MAX_BITS(MAX_BITS)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .sample  (sample),
        .commit  (burst_done),
        .cur_port(cur_port),
        .cur_bit (cur_bit),
        .sdi     (sio_din),
        .in_flat (in_flat)
    );

    // Source field of the slot being shifted.
    always_comb begin
        cur_word  = src_flat[int'(cur_port)*SRC_WORD_W +: SRC_WORD_W];
        cur_field = cur_word[int'(cur_bit)*SRC_W +: SRC_W];
    end

    // Chain pins decoded from sequencer state and timer phase.
    always_comb begin
        sio_clk  = (state == ST_SHIFT) && phase_high;
        sio_dout = (state == ST_SHIFT) && src_level(cur_field);
        sio_load = (state == ST_LOAD);
    end

endmodule

// File: rtl/sgpio_burst_checker.sv
// Property checker for the burst engine, attached through bind.
module sgpio_burst_checker #(
    parameter int IN_W = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic            sio_clk,
    input logic            sio_dout,
    input logic            sio_load,
    input logic            ss_bit,
    input logic            auto_bit,
    input logic            busy,
    input logic [IN_W-1:0] in_flat
);
    // R5: load period keeps clock and data low.
    a_r5_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sio_load |-> (!sio_clk && !sio_dout));

    // R2: pins are quiet whenever no burst is running.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sio_clk && !sio_dout && !sio_load));

    // R7: a clock rise never directly follows a load cycle.
    a_r7_no_clk_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sio_clk) |-> !$past(sio_load));

    // R8: single-shot drops by itself only at the end of a load with auto-repeat clear.
    a_r8_ss_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ss_bit) && !$past(cfg_we)) |-> ($past(sio_load) && !$past(auto_bit)));

    // R9: with auto-repeat set, single-shot holds unless software writes.
    a_r9_ss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_bit && auto_bit && !cfg_we) |=> ss_bit);

    // R6: captured words only change right after a load cycle.
    a_r6_words_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_flat) |-> $past(sio_load));

endmodule

bind sgpio_burst_engine sgpio_burst_checker #(.IN_W(IN_BITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .sio_clk (sio_clk),
    .sio_dout(sio_dout),
    .sio_load(sio_load),
    .ss_bit  (ctrl_ss),
    .auto_bit(ctrl_auto),
    .busy    (busy),
    .in_flat (in_flat)
);

// File: tb/sgpio_burst_engine_tb.sv
`timescale 1ns/1ps
module sgpio_burst_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        sio_clk, sio_dout, sio_load;
    logic        sio_din = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sgpio_burst_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sio_clk(sio_clk),
        .sio_dout(sio_dout), .sio_load(sio_load), .sio_din(sio_din)
    );

    // ---------------- reference model ----------------
    typedef struct {
        int kind;   // 0 shift slot cycle, 1 load cycle, 2 gap cycle
        bit sclk;
        int port;
        int bitn;
        bit last;
    } ent_t;

    ent_t      q[$];
    int        m_width, m_div, m_gap, m_d;
    bit        m_auto, m_ss;
    bit [31:0] m_en;
    bit [11:0] m_src[32];
    bit [31:0] m_in[4];
    bit [31:0] m_pend[4];
    bit [31:0] pat[4];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic build_burst();
        ent_t e;
        m_d = (m_div < 2) ? 2 : m_div;
        for (int b = 0; b < 4; b++) m_pend[b] = '0;
        for (int p = 0; p < 32; p++) begin
            if (m_en[p]) begin
                for (int b = 0; b <= m_width; b++) begin
                    m_pend[b][p] = pat[b][p];
                    for (int c = 0; c < m_d; c++) begin
                        e.kind = 0; e.sclk = (c >= m_d / 2); e.port = p; e.bitn = b; e.last = 0;
                        q.push_back(e);
                    end
                end
            end
        end
        for (int c = 0; c < m_d; c++) begin
            e.kind = 1; e.sclk = 0; e.port = 0; e.bitn = 0; e.last = (c == m_d - 1);
            q.push_back(e);
        end
    endtask

    // Model step at each clock edge: retire one cycle, start bursts, apply writes.
    always @(posedge clk) begin
        bit   popped;
        ent_t e;
        ent_t g;
        popped = 0;
        if (!rst_n) begin
            q.delete();
            m_width = 0; m_div = 0; m_gap = 0; m_auto = 0; m_ss = 0; m_en = '0; m_d = 2;
            for (int p = 0; p < 32; p++) m_src[p] = '0;
            for (int b = 0; b < 4; b++) begin m_in[b] = '0; m_pend[b] = '0; end
        end else begin
            if (q.size() > 0) begin
                e = q.pop_front();
                popped = 1;
                if (e.kind == 1 && e.last) begin
                    for (int b = 0; b < 4; b++) m_in[b] = m_pend[b];
                    if (!m_auto) m_ss = 0;
                    if (m_auto && m_gap != 0) begin
                        for (int i = 0; i < m_gap * m_d; i++) begin
                            g.kind = 2; g.sclk = 0; g.port = 0; g.bitn = 0; g.last = 0;
                            q.push_back(g);
                        end
                    end
                end
            end
            if (!popped && q.size() == 0 && (m_auto || m_ss)) build_burst();
            if (cfg_we) begin
                if (cfg_addr == 6'h00) begin
                    m_width = int'(cfg_wdata[1:0]); m_auto = cfg_wdata[2]; m_ss = cfg_wdata[3];
                end else if (cfg_addr == 6'h01) m_div = int'(cfg_wdata[11:0]);
                else if (cfg_addr == 6'h02) m_gap = int'(cfg_wdata[7:0]);
                else if (cfg_addr == 6'h03) m_en = cfg_wdata;
                else if (cfg_addr >= 6'h20) m_src[cfg_addr - 6'h20] = cfg_wdata[11:0];
            end
        end
    end

    // Per-cycle pin comparison and serial input drive, away from the active edge.
    always @(negedge clk) begin
        logic esclk, esdo, eld;
        esclk = 0; esdo = 0; eld = 0;
        if (rst_n && !done) begin
            if (q.size() > 0) begin
                if (q[0].kind == 0) begin
                    esclk = q[0].sclk;
                    esdo  = (m_src[q[0].port][3*q[0].bitn +: 3] == 3'd1);
                end else if (q[0].kind == 1) begin
                    eld = 1;
                end
            end
            chk("R2/R3", "sio_clk", 32'(sio_clk), 32'(esclk));
            chk("R3/R4", "sio_dout", 32'(sio_dout), 32'(esdo));
            chk("R5/R7", "sio_load", 32'(sio_load), 32'(eld));
            if (q.size() > 0 && q[0].kind == 0) sio_din = pat[q[0].bitn][q[0].port];
            else sio_din = 1'b0;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = a;
        #1;
        chk(req, $sformatf("read addr %h", a), cfg_rdata, exp);
    endtask

    function automatic logic [31:0] ctrl_exp();
        return {28'd0, m_ss, m_auto, 2'(m_width)};
    endfunction

    task automatic wait_idle();
        do @(posedge clk); while (q.size() != 0 || m_ss || m_auto);
        repeat (3) @(posedge clk);
    endtask

    task automatic check_inwords(string req);
        for (int b = 0; b < 4; b++) rd_chk(req, 6'(4 + b), m_in[b]);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        pat[0] = 32'hA5C3_0F96; pat[1] = 32'h0000_0024;
        pat[2] = 32'h8000_0001; pat[3] = 32'hFFFF_FFFF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of pins and registers
        #1;
        chk("R1", "pins after reset", {29'd0, sio_clk, sio_dout, sio_load}, 32'd0);
        rd_chk("R1", 6'h00, 32'd0);
        rd_chk("R1", 6'h01, 32'd0);
        rd_chk("R1", 6'h03, 32'd0);
        rd_chk("R1", 6'h04, 32'd0);
        rd_chk("R1", 6'h20, 32'd0);

        // R3 R4 R6 R8: two bits per port, ports 0, 2, 5, reserved source codes
        wr(6'h01, 32'd2);
        wr(6'h03, 32'h0000_0025);
        wr(6'h20, 32'h001);
        wr(6'h22, 32'h00A);
        wr(6'h25, 32'h00F);
        rd_chk("R4", 6'h22, 32'h00A);
        wr(6'h00, 32'h9);
        rd_chk("R8", 6'h00, ctrl_exp());
        wait_idle();
        check_inwords("R6");
        rd_chk("R8", 6'h00, ctrl_exp());

        // R2 R3: odd divider, four bits per port, end ports 0 and 31
        pat[0] = 32'h8000_0000; pat[1] = 32'h0000_0001; pat[2] = 32'hFFFF_FFFE; pat[3] = 32'h8000_0001;
        wr(6'h01, 32'd5);
        wr(6'h03, 32'h8000_0001);
        wr(6'h3F, 32'h249);
        wr(6'h20, 32'h1C9);
        wr(6'h00, 32'hB);
        wait_idle();
        check_inwords("R6");

        // R2: divider values below 2 clamp to 2
        wr(6'h01, 32'd1);
        wr(6'h03, 32'h0000_0010);
        wr(6'h24, 32'h001);
        wr(6'h00, 32'h8);
        wait_idle();
        wr(6'h01, 32'd0);
        wr(6'h00, 32'h8);
        wait_idle();
        check_inwords("R2");

        // R5: empty mask gives a load-only burst and clears captured words
        wr(6'h03, 32'h0);
        wr(6'h00, 32'h8);
        wait_idle();
        check_inwords("R5");

        // R10: snapshot of mask, width and divider during a running burst
        pat[0] = 32'h0000_00A0; pat[1] = 32'h0000_0050; pat[2] = 32'h0000_00F0;
        wr(6'h01, 32'd3);
        wr(6'h03, 32'h0000_00F0);
        wr(6'h00, 32'h0000_000A);
        repeat (8) @(negedge clk);
        wr(6'h03, 32'h0000_0001);
        wr(6'h01, 32'd7);
        wr(6'h00, 32'h0000_0008);
        wait_idle();
        rd_chk("R10", 6'h04, m_in[0]);
        rd_chk("R10", 6'h06, m_in[2]);

        // R7 R9: auto-repeat with a gap, single-shot held, then gap of zero
        wr(6'h01, 32'd2);
        wr(6'h03, 32'h0000_0003);
        wr(6'h02, 32'd3);
        wr(6'h00, 32'h0000_000C);
        repeat (60) @(negedge clk);
        rd_chk("R9", 6'h00, ctrl_exp());
        wr(6'h02, 32'd0);
        repeat (40) @(negedge clk);
        rd_chk("R9", 6'h00, ctrl_exp());
        rd_chk("R7", 6'h02, 32'd0);
        wr(6'h00, 32'h0000_0008);
        wait_idle();
        rd_chk("R8", 6'h00, ctrl_exp());
        check_inwords("R7");

        // R11: writes to captured words and unmapped space have no effect
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h10, 32'hFFFF_FFFF);
        rd_chk("R11", 6'h04, m_in[0]);
        rd_chk("R11", 6'h10, 32'd0);
        rd_chk("R11", 6'h00, ctrl_exp());
        rd_chk("R11", 6'h03, m_en);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule